// File: doc/BRIEF.md
# Paired Store Write Port

This block sits between a store queue and the data array of a cache with 64-byte lines. Each cycle the queue may offer its two oldest stores: slot A holds the older one, slot B the younger. The block owns one physical write port. Each cycle it sends one line-addressed write to the array, made of a line address, 64 data bytes and a 64-bit byte-enable mask. Each enabled byte is written and all other bytes are left alone.

Two stores go out as a single write only when all of the following hold:
- both lie wholly inside the same line;
- both carry the same memory-type code;
- neither needs more than one port beat.

In every other case the stores leave one after the other, oldest first. A store that is wider than 32 bytes, or that crosses a line boundary, is cut into line-local pieces of at most 32 bytes each. The pieces go out on successive cycles.

The input side uses valid/ready, one pair per slot. A slot is consumed only in a cycle where both its valid and its ready are high. While slot A is valid and not ready, the queue must hold slot A steady. Slot B can be accepted only together with slot A. After A is accepted alone, the queue moves its younger store into slot A. The array side has no back-pressure.

Top module: `store_pair_writer`

## Requirements
- R1: Two stores are accepted in the same cycle and leave as one write carrying the union of their byte enables when all of these hold: the older store has issued none of its bytes yet; both stores are valid; they share address bits [63:6]; they have equal 3-bit memory types; and each store has a size of at most 32 bytes and does not cross a line.
- R2: Every write that is not a merged pair enables at most 32 bytes, and each store piece takes exactly one write cycle.
- R3: b_ready is never high unless a_ready is high. A store offered on slot B while slot A is idle is not accepted and produces no write.
- R4: Stores whose memory types differ, or that lie in different lines, are issued on separate cycles, the slot A store first.
- R5: A store larger than 32 bytes is issued as successive pieces, with a_ready low until the cycle of its final piece. A line-aligned 64-byte store takes two cycles, and a 33-byte store takes two cycles.
- R6: A store that crosses a 64-byte line boundary is cut at the boundary. Each piece is written to its own line.
- R7: When a merged pair covers the same byte, the slot B (younger) store's byte is written.
- R8: A piece offered in cycle N appears on the wr_* outputs in cycle N+1. Byte i of a store's data (bits 8i+7:8i) lands at byte address addr+i. wr_data byte j and wr_be bit j refer to byte offset j of line wr_line.
- R9: A synchronous active-low reset deasserts wr_en and discards a partly issued store. The next store offered after reset starts from its first byte.
- R10: A store's size field gives its length in bytes, from 1 to 64. Slot A must stay unchanged while a_valid is high and a_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Older store offered |
| a_ready | output | 1 | Older store consumed this cycle |
| a_addr | input | 64 | Byte address of the older store |
| a_size | input | 7 | Length of the older store in bytes (1 to 64) |
| a_mtype | input | 3 | Memory-type code of the older store |
| a_data | input | 512 | Older store data, byte i at addr+i |
| b_valid | input | 1 | Younger store offered |
| b_ready | output | 1 | Younger store consumed this cycle |
| b_addr | input | 64 | Byte address of the younger store |
| b_size | input | 7 | Length of the younger store in bytes (1 to 64) |
| b_mtype | input | 3 | Memory-type code of the younger store |
| b_data | input | 512 | Younger store data, byte i at addr+i |
| wr_en | output | 1 | Array write strobe |
| wr_line | output | 58 | Line address (byte address bits 63:6) |
| wr_mtype | output | 3 | Memory type of the write |
| wr_data | output | 512 | Line-aligned write data |
| wr_be | output | 64 | Byte enables, bit j for line offset j |

## Verification
The ready outputs are combinational and belong to the same cycle as the offer. The bench drives the slots on the falling edge and reads a_ready and b_ready one time unit later, before the rising edge that consumes them. A write is registered, so it is due one cycle after its piece was offered. The bench checks wr_* at the next falling edge, and a byte-enabled line memory in the bench stores each write on the rising edge where it is presented. Array contents are compared two cycles after the last acceptance of each vector, when the final write is certain to have landed. The number of offer cycles per vector is checked against a count worked out by hand from the piece rules.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int unsigned STW_ADDR_W = 64;
  localparam int unsigned STW_LINE_B = 64;
  localparam int unsigned STW_PORT_B = 32;
  localparam int unsigned STW_MT_W   = 3;
  localparam int unsigned STW_OFF_W  = $clog2(STW_LINE_B);
  localparam int unsigned STW_LEN_W  = STW_OFF_W + 1;
endpackage

// File: rtl/stw_piece.sv
module stw_piece #(
  parameter int unsigned ADDR_W = stw_pkg::STW_ADDR_W,
  parameter int unsigned LINE_B = stw_pkg::STW_LINE_B,
  parameter int unsigned PORT_B = stw_pkg::STW_PORT_B,
  localparam int unsigned OFF_W = $clog2(LINE_B),
  localparam int unsigned LEN_W = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  total,
  input  logic [LEN_W-1:0]  sent,
  output logic [ADDR_W-1:0] at,
  output logic [LEN_W-1:0]  len,
  output logic              final_piece
);
  logic [LEN_W-1:0] rest;
  logic [LEN_W-1:0] room;

  assign at   = base + ADDR_W'(sent);
  assign rest = total - sent;
  // bytes left before the end of the line holding 'at'
  assign room = LEN_W'(LINE_B) - {1'b0, at[OFF_W-1:0]};

  always_comb begin
    len = rest;
    if (len > LEN_W'(PORT_B)) len = LEN_W'(PORT_B);
    if (len > room) len = room;
  end

  assign final_piece = (len == rest);
endmodule

// File: rtl/stw_lanes.sv
module stw_lanes #(
  parameter int unsigned LINE_B = stw_pkg::STW_LINE_B,
  localparam int unsigned OFF_W = $clog2(LINE_B),
  localparam int unsigned LEN_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0]    start,
  input  logic [LEN_W-1:0]    len,
  input  logic [LEN_W-1:0]    skip,
  input  logic [8*LINE_B-1:0] src,
  output logic [LINE_B-1:0]   be,
  output logic [8*LINE_B-1:0] bytes
);
  always_comb begin
    int rel;
    logic [OFF_W-1:0] pick;
    be    = '0;
    bytes = '0;
    for (int j = 0; j < LINE_B; j++) begin
      rel  = j - int'(start);
      pick = OFF_W'(int'(skip) + rel);
      if (rel >= 0 && rel < int'(len)) begin
        be[j]          = 1'b1;
        bytes[8*j +: 8] = src[8*pick +: 8];
      end
    end
  end
endmodule

// File: rtl/store_pair_writer.sv
module store_pair_writer #(
  parameter int unsigned ADDR_W = stw_pkg::STW_ADDR_W,
  parameter int unsigned LINE_B = stw_pkg::STW_LINE_B,
  parameter int unsigned PORT_B = stw_pkg::STW_PORT_B,
  parameter int unsigned MT_W   = stw_pkg::STW_MT_W,
  localparam int unsigned OFF_W = $clog2(LINE_B),
  localparam int unsigned LEN_W = OFF_W + 1,
  localparam int unsigned LINE_W = ADDR_W - OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [LEN_W-1:0]    a_size,
  input  logic [MT_W-1:0]     a_mtype,
  input  logic [8*LINE_B-1:0] a_data,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic [ADDR_W-1:0]   b_addr,
  input  logic [LEN_W-1:0]    b_size,
  input  logic [MT_W-1:0]     b_mtype,
  input  logic [8*LINE_B-1:0] b_data,
  output logic                wr_en,
  output logic [LINE_W-1:0]   wr_line,
  output logic [MT_W-1:0]     wr_mtype,
  output logic [8*LINE_B-1:0] wr_data,
  output logic [LINE_B-1:0]   wr_be
);
  logic [LEN_W-1:0]    sent_q;
  logic                pair_q;
  logic [ADDR_W-1:0]   a_at, b_at;
  logic [LEN_W-1:0]    a_len, b_len;
  logic                a_last, b_last;
  logic [LINE_B-1:0]   a_be, b_be, m_be;
  logic [8*LINE_B-1:0] a_bytes, b_bytes, m_bytes;
  logic                pair_ok;

  stw_piece #(.ADDR_W(ADDR_W), .LINE_B(LINE_B), .PORT_B(PORT_B)) u_piece_a (
    .base(a_addr), .total(a_size), .sent(sent_q),
    .at(a_at), .len(a_len), .final_piece(a_last));

  stw_piece #(.ADDR_W(ADDR_W), .LINE_B(LINE_B), .PORT_B(PORT_B)) u_piece_b (
    .base(b_addr), .total(b_size), .sent('0),
    .at(b_at), .len(b_len), .final_piece(b_last));

  stw_lanes #(.LINE_B(LINE_B)) u_lanes_a (
    .start(a_at[OFF_W-1:0]), .len(a_len), .skip(sent_q), .src(a_data),
    .be(a_be), .bytes(a_bytes));

  stw_lanes #(.LINE_B(LINE_B)) u_lanes_b (
    .start(b_at[OFF_W-1:0]), .len(b_len), .skip('0), .src(b_data),
    .be(b_be), .bytes(b_bytes));

  // both must be untouched single-beat stores in one line with one type
  assign pair_ok = a_valid && b_valid && (sent_q == '0) && a_last && b_last &&
                   (a_at[ADDR_W-1:OFF_W] == b_at[ADDR_W-1:OFF_W]) &&
                   (a_mtype == b_mtype);

  assign a_ready = a_valid && a_last;
  assign b_ready = pair_ok;

  // younger store wins on overlapping bytes
  generate
    for (genvar g = 0; g < LINE_B; g++) begin : g_merge
      assign m_be[g]          = a_be[g] | (pair_ok & b_be[g]);
      assign m_bytes[8*g +: 8] = (pair_ok && b_be[g]) ? b_bytes[8*g +: 8]
                                                      : a_bytes[8*g +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en  <= 1'b0;
      pair_q <= 1'b0;
      sent_q <= '0;
    end else begin
      wr_en  <= a_valid;
      pair_q <= pair_ok;
      if (a_valid) sent_q <= a_last ? '0 : sent_q + a_len;
    end
  end

  always_ff @(posedge clk) begin
    if (a_valid) begin
      wr_line  <= a_at[ADDR_W-1:OFF_W];
      wr_mtype <= a_mtype;
      wr_data  <= m_bytes;
      wr_be    <= m_be;
    end
  end

  // R3: the younger slot never retires ahead of the older one
  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    b_ready |-> a_ready);

  // R5: a store wider than one beat cannot finish in its first cycle
  a_r5_split: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && sent_q == '0 && a_size > LEN_W'(PORT_B)) |-> !a_ready);

  // R2: a lone piece never enables more than one beat of bytes
  a_r2_beat_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pair_q) |-> ($countones(wr_be) <= PORT_B));

  // R8: every offered cycle produces a write on the next cycle
  a_r8_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |=> wr_en);

  // R10: the queue holds the older slot until it is consumed
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_ready) |=> (a_valid && $stable(a_addr) && $stable(a_size)));

  // R10: legal sizes only
  a_r10_size: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (a_size != '0 && a_size <= LEN_W'(LINE_B)));
endmodule

// File: tb/store_pair_writer_tb.sv
module store_pair_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] HI = 64'hABCD_0000_0000_0000;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [15:0] aad; logic [6:0] asz; logic [2:0] amt;
    logic        bv;  logic [15:0] bad; logic [6:0] bsz; logic [2:0] bmt;
    logic [3:0]  ncyc; logic ra1; logic rb1;
  } vec_t;

  // a-addr, a-size, a-mt, b-valid, b-addr, b-size, b-mt, cycles, a_ready@1, b_ready@1
  localparam vec_t VEC [NVEC] = '{
    '{16'h040, 7'd8,  3'd1, 1'b1, 16'h050, 7'd8,  3'd1, 4'd1, 1'b1, 1'b1},
    '{16'h080, 7'd8,  3'd1, 1'b1, 16'h090, 7'd8,  3'd2, 4'd2, 1'b1, 1'b0},
    '{16'h0C0, 7'd8,  3'd1, 1'b1, 16'h100, 7'd8,  3'd1, 4'd2, 1'b1, 1'b0},
    '{16'h13C, 7'd8,  3'd0, 1'b1, 16'h150, 7'd4,  3'd0, 4'd3, 1'b0, 1'b0},
    '{16'h180, 7'd64, 3'd0, 1'b0, 16'h000, 7'd1,  3'd0, 4'd2, 1'b0, 1'b0},
    '{16'h200, 7'd16, 3'd4, 1'b1, 16'h208, 7'd16, 3'd4, 4'd1, 1'b1, 1'b1},
    '{16'h250, 7'd40, 3'd0, 1'b0, 16'h000, 7'd1,  3'd0, 4'd2, 1'b0, 1'b0},
    '{16'h2B0, 7'd64, 3'd2, 1'b0, 16'h000, 7'd1,  3'd0, 4'd3, 1'b0, 1'b0},
    '{16'h300, 7'd32, 3'd5, 1'b1, 16'h320, 7'd32, 3'd5, 4'd1, 1'b1, 1'b1},
    '{16'h340, 7'd8,  3'd0, 1'b1, 16'h378, 7'd16, 3'd0, 4'd3, 1'b1, 1'b0},
    '{16'h3A0, 7'd33, 3'd0, 1'b0, 16'h000, 7'd1,  3'd0, 4'd2, 1'b0, 1'b0},
    '{16'h3C0, 7'd4,  3'd3, 1'b1, 16'h3C0, 7'd4,  3'd3, 4'd1, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic a_ready, b_ready;
  logic [63:0] a_addr = '0, b_addr = '0;
  logic [6:0]  a_size = 7'd1, b_size = 7'd1;
  logic [2:0]  a_mtype = '0, b_mtype = '0;
  logic [511:0] a_data = '0, b_data = '0;
  logic wr_en;
  logic [57:0] wr_line;
  logic [2:0] wr_mtype;
  logic [511:0] wr_data;
  logic [63:0] wr_be;

  int total = 0, bad = 0, wr_cnt = 0;
  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  store_pair_writer dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr), .a_size(a_size),
    .a_mtype(a_mtype), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_addr(b_addr), .b_size(b_size),
    .b_mtype(b_mtype), .b_data(b_data),
    .wr_en(wr_en), .wr_line(wr_line), .wr_mtype(wr_mtype),
    .wr_data(wr_data), .wr_be(wr_be));

  // line-addressed byte-enabled array model
  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      for (int j = 0; j < 64; j++)
        if (wr_be[j]) mem[{wr_line[3:0], 6'(j)}] <= wr_data[8*j +: 8];
    end
  end

  function automatic logic [511:0] mk_data(input logic [7:0] seed);
    logic [511:0] d;
    for (int i = 0; i < 64; i++) d[8*i +: 8] = seed + 8'(i);
    return d;
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0, 8:      return "R1";
      1, 2:      return "R4";
      3, 7, 9:   return "R6";
      5, 11:     return "R7";
      default:   return "R5";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic put_exp(input logic [15:0] ad, input logic [6:0] sz, input logic [7:0] seed);
    for (int i = 0; i < int'(sz); i++) exp_mem[10'(ad + 16'(i))] = seed + 8'(i);
  endtask

  task automatic cmp_mem(input string tag);
    int mis = -1;
    for (int j = 0; j < 1024; j++)
      if (mis < 0 && mem[j] !== exp_mem[j]) mis = j;
    if (mis < 0) chk(1'b1, tag, "array", 0, 0);
    else chk(1'b0, tag, $sformatf("array byte %0h", mis), 64'(mem[mis]), 64'(exp_mem[mis]));
  endtask

  task automatic run_vec(input int i);
    vec_t v = VEC[i];
    logic [7:0] sa = 8'(16 * i + 1), sb = 8'(16 * i + 9);
    int cyc = 0, w0;
    logic fa = 1'b0, fb = 1'b0, ra, rb;
    put_exp(v.aad, v.asz, sa);
    if (v.bv) put_exp(v.bad, v.bsz, sb);
    @(negedge clk);
    w0 = wr_cnt;
    a_valid = 1'b1; a_addr = HI + 64'(v.aad); a_size = v.asz; a_mtype = v.amt; a_data = mk_data(sa);
    b_valid = v.bv; b_addr = HI + 64'(v.bad); b_size = v.bsz; b_mtype = v.bmt; b_data = mk_data(sb);
    while (a_valid && cyc < 20) begin
      #1; ra = a_ready; rb = b_ready;
      if (cyc == 0) begin fa = ra; fb = rb; end
      cyc++;
      @(negedge clk);
      if (rb) begin a_valid = 1'b0; b_valid = 1'b0; end
      else if (ra) begin
        if (b_valid) begin
          a_addr = b_addr; a_size = b_size; a_mtype = b_mtype; a_data = b_data;
          b_valid = 1'b0;
        end else a_valid = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    chk(cyc == int'(v.ncyc), tag_of(i), $sformatf("vec %0d offer cycles", i), 64'(cyc), 64'(v.ncyc));
    chk(fa == v.ra1, "R10", $sformatf("vec %0d first a_ready", i), 64'(fa), 64'(v.ra1));
    chk(fb == v.rb1, "R10", $sformatf("vec %0d first b_ready", i), 64'(fb), 64'(v.rb1));
    chk(wr_cnt - w0 == int'(v.ncyc), "R2", $sformatf("vec %0d writes", i), 64'(wr_cnt - w0), 64'(v.ncyc));
    cmp_mem(i == 5 || i == 11 ? "R7" : "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 1024; j++) begin mem[j] = '0; exp_mem[j] = '0; end
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R9", "wr_en in reset", 64'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 1'b0, "R9", "wr_en after reset", 64'(wr_en), 0);
    chk(a_ready == 1'b0 && b_ready == 1'b0, "R9", "readies idle", 64'({a_ready, b_ready}), 0);

    // R3: younger slot alone is not taken
    b_valid = 1'b1; b_addr = HI + 64'h040; b_size = 7'd8; b_data = mk_data(8'h77);
    #1; chk(b_ready == 1'b0, "R3", "b_ready without a", 64'(b_ready), 0);
    @(negedge clk);
    chk(wr_en == 1'b0, "R3", "no write for lone b", 64'(wr_en), 0);
    b_valid = 1'b0;

    // R9: reset in the middle of a split store
    a_valid = 1'b1; a_addr = HI; a_size = 7'd64; a_mtype = 3'd0; a_data = mk_data(8'h20);
    #1; chk(a_ready == 1'b0, "R5", "64B first cycle", 64'(a_ready), 0);
    @(negedge clk);
    a_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    a_valid = 1'b1; a_addr = HI + 64'h010; a_size = 7'd8; a_data = mk_data(8'h50);
    #1; chk(a_ready == 1'b1, "R9", "fresh store after reset", 64'(a_ready), 1);
    @(negedge clk);
    a_valid = 1'b0;
    chk(wr_en == 1'b1, "R8", "write one cycle later", 64'(wr_en), 1);
    chk(wr_line == 58'((HI + 64'h010) >> 6), "R8", "wr_line", 64'(wr_line), (HI + 64'h010) >> 6);
    chk(wr_be == (64'hFF << 16), "R8", "wr_be", wr_be, 64'hFF << 16);
    chk(wr_data[8*16 +: 8] == 8'h50 && wr_data[8*23 +: 8] == 8'h57, "R8", "wr_data bytes",
        64'({wr_data[8*16 +: 8], wr_data[8*23 +: 8]}), 64'h5057);
    @(negedge clk);
    chk(wr_en == 1'b0, "R8", "single write", 64'(wr_en), 0);
    for (int j = 0; j < 1024; j++) exp_mem[j] = mem[j];

    for (int i = 0; i < NVEC; i++) run_vec(i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule